// File: doc/BRIEF.md
# Single-Beat Memory-Mapped Slave to PCI Express Request Bridge

This block sits between a 32-bit memory-mapped master and the transmit side of a PCI Express transaction layer. Every read or write command the master presents becomes one memory request packet. A write becomes a posted memory write that carries its data in the packet. A read becomes a non-posted memory read. The data from the completion that answers the read is then returned to the master on the read-data port.

Only one command is in flight at any time. The master is stalled with a wait signal from the cycle a command is accepted until the block is done with it. A write is done once its last packet dword has been taken by the transmit stream. A read is done once its completion has arrived and the data has been handed back. The packet leaves as a dword-serial stream with a valid/ready handshake and start and end markers. Completions come in as pre-parsed fields (valid, tag, data dword). The block always accepts them.

Top module: `avpcie_req_bridge`

## Requirements
- R1: While `av_sel` is low, `av_rd` and `av_wr` are ignored: no packet starts and `av_wait` stays low.
- R2: `av_wait` is low while the block is idle, and a command is taken only on a cycle where `av_sel` is high, a strobe is high and `av_wait` is low. `av_wait` is high from the cycle after acceptance until the command finishes, and `tx_valid` is never high while `av_wait` is low.
- R3: A write sends four dwords. Dword 0 is 0x40000001 (format 010, type 00000, length 1). Dword 1 is {REQ_ID[15:0], 8'h00, 4'b0000, av_be}. Dword 2 is the byte address with bits [1:0] cleared. Dword 3 is `av_wdata`.
- R4: A read sends three dwords. Dword 0 is 0x00000001 (format 000, type 00000, length 1). Dword 1 is {REQ_ID[15:0], tag[7:0], 4'b0000, 4'b1111}. Dword 2 is the byte address with bits [1:0] cleared. Addresses narrower than 32 bits are zero-extended.
- R5: The first read after reset carries tag 0. Each later read carries the previous read's tag plus one, modulo 2^TAG_W.
- R6: `tx_sop` is high only on dword 0 and `tx_eop` only on the last dword. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R7: After a write, `av_wait` is low in the cycle after the handshake of the last dword.
- R8: In the cycle after a completion whose tag matches the waiting read, `av_rvalid` is high for exactly one cycle with `av_rdata` equal to the completion data and `av_wait` still high. `av_wait` falls in the following cycle.
- R9: Completions whose tag does not match, and completions that arrive while no read is waiting, produce no `av_rvalid` and leave the block waiting or idle as before.
- R10: When `av_rd` and `av_wr` are both high on an accepted cycle, the command is a write.
- R11: During and right after reset, `av_wait`, `tx_valid` and `av_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| av_sel | input | 1 | Slave select; strobes count only when high |
| av_rd | input | 1 | Read command strobe |
| av_wr | input | 1 | Write command strobe |
| av_addr | input | ADDR_W | Byte address |
| av_wdata | input | 32 | Write data |
| av_be | input | 4 | Write byte enables |
| av_rdata | output | 32 | Read data returned from the completion |
| av_rvalid | output | 1 | One-cycle qualifier for av_rdata |
| av_wait | output | 1 | Stall; the command is held while high |
| tx_valid | output | 1 | Transmit dword valid |
| tx_ready | input | 1 | Transmit sink takes the dword |
| tx_data | output | 32 | Transmit dword |
| tx_sop | output | 1 | First dword of a packet |
| tx_eop | output | 1 | Last dword of a packet |
| cpl_valid | input | 1 | Completion fields valid this cycle |
| cpl_tag | input | 8 | Tag of the incoming completion |
| cpl_data | input | 32 | Data dword of the incoming completion |

## Verification
The assertions assume the master keeps its command steady until the cycle `av_wait` goes low. They also assume that a completion is a single-cycle event, and that a completion whose tag matches arrives only after the matching read request has been sent. The bench honours all three. Commands are applied at the falling edge and held until `av_wait` is seen low. Completions are driven for one cycle, and only once the read packet's last dword has been handed over. Random backpressure on `tx_ready` and a deliberately wrong tag are mixed in, and both stay inside these assumptions.

// File: rtl/avpcie_req_pkg.sv
// Shared types and constants for the memory-mapped to PCI Express request bridge.
// Assumes 32-bit addressing in the request header (3-dword header only).
package avpcie_req_pkg;

    localparam int DW_W   = 32;
    localparam int BEAT_W = 2;

    localparam logic [2:0] FMT_3DW_NODATA = 3'b000;
    localparam logic [2:0] FMT_3DW_DATA   = 3'b010;
    localparam logic [4:0] TYPE_MEM       = 5'b00000;
    localparam logic [9:0] LEN_ONE_DW     = 10'd1;

    localparam logic [BEAT_W-1:0] WR_LAST_BEAT = 2'd3;
    localparam logic [BEAT_W-1:0] RD_LAST_BEAT = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT_CPL,
        ST_RESP
    } req_state_e;

    typedef struct packed {
        logic              is_wr;
        logic [DW_W-1:0]   addr;
        logic [DW_W-1:0]   wdata;
        logic [3:0]        be;
        logic [7:0]        tag;
    } req_cmd_t;

    // Header dword 0: format, type and a length of one dword
    function automatic logic [DW_W-1:0] hdr_dw0(input logic is_wr);
        logic [DW_W-1:0] d;
        d        = '0;
        d[31:29] = is_wr ? FMT_3DW_DATA : FMT_3DW_NODATA;
        d[28:24] = TYPE_MEM;
        d[9:0]   = LEN_ONE_DW;
        return d;
    endfunction

endpackage

// File: rtl/avpcie_cpl_match.sv
// Completion filter: flags a completion whose tag equals the tag of the read
// that is currently waiting. Assumes completions arrive as one-cycle events.
module avpcie_cpl_match (
    input  logic       armed,
    input  logic       cpl_valid,
    input  logic [7:0] cpl_tag,
    input  logic [7:0] exp_tag,
    output logic       cpl_hit
);

    // Accept only while a read is waiting and only for its own tag
    always_comb begin
        cpl_hit = armed && cpl_valid && (cpl_tag == exp_tag);
    end

endmodule

// File: rtl/avpcie_tlp_fmt.sv
// Request packet formatter: picks the dword for the current beat out of the
// captured command. Assumes the command is stable for the whole packet.
module avpcie_tlp_fmt
    import avpcie_req_pkg::*;
#(
    parameter logic [15:0] REQ_ID = 16'h0100
) (
    input  req_cmd_t           cmd,
    input  logic [BEAT_W-1:0]  beat,
    output logic [DW_W-1:0]    dw,
    output logic               sop,
    output logic               eop
);

    logic [DW_W-1:0]   dw1;
    logic [BEAT_W-1:0] last_idx;

    // Dword 1: requester id, tag, last and first byte enables
    always_comb begin
        dw1[31:16] = REQ_ID;
        dw1[15:8]  = cmd.tag;
        dw1[7:4]   = 4'b0000;
        dw1[3:0]   = cmd.is_wr ? cmd.be : 4'b1111;
    end

    // Beat selection and packet boundary markers
    always_comb begin
        last_idx = cmd.is_wr ? WR_LAST_BEAT : RD_LAST_BEAT;
        case (beat)
            2'd0:    dw = hdr_dw0(cmd.is_wr);
            2'd1:    dw = dw1;
            2'd2:    dw = cmd.addr;
            default: dw = cmd.wdata;
        endcase
        sop = (beat == '0);
        eop = (beat == last_idx);
    end

endmodule

// File: rtl/avpcie_req_ctrl.sv
// Command controller: accepts one command at a time, walks the packet beats,
// waits for the read completion and returns its data. Assumes the master
// holds its command until the wait signal is low.
module avpcie_req_ctrl
    import avpcie_req_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               av_sel,
    input  logic               av_rd,
    input  logic               av_wr,
    input  logic [ADDR_W-1:0]  av_addr,
    input  logic [DW_W-1:0]    av_wdata,
    input  logic [3:0]         av_be,
    output logic               av_wait,
    output logic [DW_W-1:0]    av_rdata,
    output logic               av_rvalid,
    output logic               tx_valid,
    input  logic               tx_ready,
    input  logic               pkt_last,
    output logic [BEAT_W-1:0]  beat,
    output req_cmd_t           cmd,
    output logic               cpl_armed,
    input  logic               cpl_hit,
    input  logic [DW_W-1:0]    cpl_data
);

    localparam int TAG_FIELD_W = 8;

    req_state_e        state;
    logic [TAG_W-1:0]  tag_ctr;
    logic [DW_W-1:0]   addr_ext;
    logic              accept;

    // Widen or trim the byte address to the 32-bit header field
    generate
        if (ADDR_W < DW_W) begin : g_addr_pad
            assign addr_ext = {{(DW_W-ADDR_W){1'b0}}, av_addr};
        end else begin : g_addr_fit
            assign addr_ext = av_addr[DW_W-1:0];
        end
    endgenerate

    // Acceptance decode: idle, selected and at least one strobe
    always_comb begin
        accept = (state == ST_IDLE) && av_sel && (av_rd || av_wr);
    end

    // Main sequencer: capture, send beats, await completion, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            beat      <= '0;
            tag_ctr   <= '0;
            cmd       <= '0;
            av_rdata  <= '0;
            av_rvalid <= 1'b0;
        end else begin
            av_rvalid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd.is_wr <= av_wr;
                        cmd.addr  <= addr_ext & ~32'h3;
                        cmd.wdata <= av_wdata;
                        cmd.be    <= av_be;
                        cmd.tag   <= av_wr ? '0 : TAG_FIELD_W'(tag_ctr);
                        if (!av_wr) begin
                            tag_ctr <= tag_ctr + 1'b1;
                        end
                        beat  <= '0;
                        state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        if (pkt_last) begin
                            state <= cmd.is_wr ? ST_IDLE : ST_WAIT_CPL;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                ST_WAIT_CPL: begin
                    if (cpl_hit) begin
                        av_rdata  <= cpl_data;
                        av_rvalid <= 1'b1;
                        state     <= ST_RESP;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Handshake outputs derived from the sequencer state
    always_comb begin
        av_wait   = (state != ST_IDLE);
        tx_valid  = (state == ST_SEND);
        cpl_armed = (state == ST_WAIT_CPL);
    end

    assert_rvalid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        av_rvalid |=> !av_rvalid);

    assert_rvalid_in_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        av_rvalid |-> av_wait);

    assert_tx_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> av_wait);

    assert_start_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && $past(state) == ST_IDLE) |-> $past(av_sel && (av_rd || av_wr)));

    assert_write_precedence_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && $past(state) == ST_IDLE && $past(av_wr)) |-> cmd.is_wr);

endmodule

// File: rtl/avpcie_req_bridge.sv
// Top of the memory-mapped slave to PCI Express request bridge. Ties the
// controller, packet formatter and completion filter together. Assumes one
// command in flight and single-cycle completion events.
module avpcie_req_bridge
    import avpcie_req_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          TAG_W  = 8,
    parameter logic [15:0] REQ_ID = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              av_sel,
    input  logic              av_rd,
    input  logic              av_wr,
    input  logic [ADDR_W-1:0] av_addr,
    input  logic [31:0]       av_wdata,
    input  logic [3:0]        av_be,
    output logic [31:0]       av_rdata,
    output logic              av_rvalid,
    output logic              av_wait,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    input  logic              cpl_valid,
    input  logic [7:0]        cpl_tag,
    input  logic [31:0]       cpl_data
);

    req_cmd_t          cmd;
    logic [BEAT_W-1:0] beat;
    logic              cpl_armed;
    logic              cpl_hit;

    avpcie_req_ctrl #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .av_sel    (av_sel),
        .av_rd     (av_rd),
        .av_wr     (av_wr),
        .av_addr   (av_addr),
        .av_wdata  (av_wdata),
        .av_be     (av_be),
        .av_wait   (av_wait),
        .av_rdata  (av_rdata),
        .av_rvalid (av_rvalid),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .pkt_last  (tx_eop),
        .beat      (beat),
        .cmd       (cmd),
        .cpl_armed (cpl_armed),
        .cpl_hit   (cpl_hit),
        .cpl_data  (cpl_data)
    );

    avpcie_tlp_fmt #(
        .REQ_ID (REQ_ID)
    ) u_fmt (
        .cmd  (cmd),
        .beat (beat),
        .dw   (tx_data),
        .sop  (tx_sop),
        .eop  (tx_eop)
    );

    avpcie_cpl_match u_match (
        .armed     (cpl_armed),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .exp_tag   (cmd.tag),
        .cpl_hit   (cpl_hit)
    );

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_rvalid_from_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(av_rvalid) |-> $past(cpl_valid && cpl_tag == cmd.tag));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(!rst_n) |-> (!av_wait && !tx_valid && !av_rvalid));

endmodule

// File: tb/avpcie_req_bridge_test.sv
`timescale 1ns/1ps
module avpcie_req_bridge_test;

    localparam logic [15:0] RID = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        av_sel = 0, av_rd = 0, av_wr = 0;
    logic [31:0] av_addr = 0, av_wdata = 0;
    logic [3:0]  av_be = 0;
    logic [31:0] av_rdata;
    logic        av_rvalid, av_wait;
    logic        tx_valid, tx_sop, tx_eop;
    logic        tx_ready = 0;
    logic [31:0] tx_data;
    logic        cpl_valid = 0;
    logic [7:0]  cpl_tag = 0;
    logic [31:0] cpl_data = 0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] exp_tag = 0;

    always #5 clk = ~clk;

    avpcie_req_bridge uut (
        .clk(clk), .rst_n(rst_n), .av_sel(av_sel), .av_rd(av_rd), .av_wr(av_wr),
        .av_addr(av_addr), .av_wdata(av_wdata), .av_be(av_be),
        .av_rdata(av_rdata), .av_rvalid(av_rvalid), .av_wait(av_wait),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_eop(tx_eop),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data)
    );

    function automatic logic [31:0] want_dw0(input bit wr);
        return wr ? 32'h4000_0001 : 32'h0000_0001;
    endfunction

    function automatic logic [31:0] want_dw1(input bit wr, input logic [7:0] tag, input logic [3:0] be);
        return wr ? {RID, 8'h00, 4'h0, be} : {RID, tag, 4'h0, 4'hF};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One command end to end; bad_tag sends a wrong completion first
    task automatic run_cmd(input bit wr, input bit rd, input logic [31:0] addr,
                           input logic [31:0] wd, input logic [3:0] be,
                           input bit bp, input bit bad_tag, input logic [31:0] rdv);
        bit           eff_wr;
        int           n, beats, guard;
        logic [31:0]  got [4];
        logic [31:0]  want [4];
        eff_wr = wr;
        n = eff_wr ? 4 : 3;
        want[0] = want_dw0(eff_wr);
        want[1] = want_dw1(eff_wr, exp_tag, be);
        want[2] = addr & ~32'h3;
        want[3] = wd;
        @(negedge clk);
        av_sel = 1; av_wr = wr; av_rd = rd; av_addr = addr; av_wdata = wd; av_be = be;
        #1;
        while (av_wait) begin @(negedge clk); #1; end
        @(posedge clk);
        beats = 0; guard = 0;
        while (beats < n && guard < 200) begin
            @(negedge clk);
            av_sel = 0; av_wr = 0; av_rd = 0;
            tx_ready = bp ? 1'($urandom % 2) : 1'b1;
            #1;
            check(beats == 0 || av_wait, "R2 busy during packet", {31'd0, av_wait}, 32'd1);
            if (tx_valid && tx_ready) begin
                got[beats] = tx_data;
                check(tx_sop == (beats == 0), "R6 sop", {31'd0, tx_sop}, {31'd0, beats == 0});
                check(tx_eop == (beats == n-1), "R6 eop", {31'd0, tx_eop}, {31'd0, beats == n-1});
                beats++;
            end
            @(posedge clk);
            guard++;
        end
        @(negedge clk);
        tx_ready = 0;
        #1;
        for (int i = 0; i < n; i++) begin
            check(got[i] === want[i], eff_wr ? "R3 write dword" : "R4/R5 read dword", got[i], want[i]);
        end
        if (eff_wr) begin
            check(!av_wait, "R7 write release", {31'd0, av_wait}, 32'd0);
            return;
        end
        check(av_wait && !tx_valid, "R2 read waits", {31'd0, av_wait}, 32'd1);
        if (bad_tag) begin
            cpl_valid = 1; cpl_tag = exp_tag + 8'd1; cpl_data = ~rdv;
            @(posedge clk);
            @(negedge clk);
            cpl_valid = 0;
            #1;
            check(!av_rvalid && av_wait, "R9 wrong tag dropped", {31'd0, av_rvalid}, 32'd0);
        end
        repeat ($urandom % 3) @(negedge clk);
        cpl_valid = 1; cpl_tag = exp_tag; cpl_data = rdv;
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 0;
        #1;
        check(av_rvalid && av_wait, "R8 rvalid with wait", {30'd0, av_rvalid, av_wait}, 32'd3);
        check(av_rdata == rdv, "R8 read data", av_rdata, rdv);
        @(negedge clk);
        #1;
        check(!av_rvalid && !av_wait, "R8 single pulse then release", {30'd0, av_rvalid, av_wait}, 32'd0);
        exp_tag++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240605));
        repeat (3) @(negedge clk);
        #1;
        check(!av_wait && !tx_valid && !av_rvalid, "R11 reset state",
              {29'd0, av_wait, tx_valid, av_rvalid}, 32'd0);
        rst_n = 1;
        @(negedge clk); #1;
        check(!av_wait && !tx_valid && !av_rvalid, "R11 after reset",
              {29'd0, av_wait, tx_valid, av_rvalid}, 32'd0);

        // R1: strobes without select do nothing
        av_sel = 0; av_rd = 1; av_wr = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            check(!tx_valid && !av_wait, "R1 strobes ignored", {30'd0, tx_valid, av_wait}, 32'd0);
        end
        av_rd = 0; av_wr = 0;

        // R9: completion while idle is ignored
        cpl_valid = 1; cpl_tag = 8'd0; cpl_data = 32'hDEAD_BEEF;
        @(negedge clk); cpl_valid = 0; #1;
        check(!av_rvalid && !av_wait, "R9 idle completion ignored", {31'd0, av_rvalid}, 32'd0);

        // Directed corner cases
        run_cmd(1, 0, 32'h1000_0007, 32'hA5A5_0001, 4'b0110, 0, 0, 0);      // R3 unaligned addr
        run_cmd(0, 1, 32'h2000_0010, 0, 4'h0, 0, 1, 32'h1234_5678);          // R4 R5 tag 0, R9
        run_cmd(0, 1, 32'hFFFF_FFFC, 0, 4'h0, 1, 0, 32'h0BAD_F00D);          // R5 tag 1, R6 bp
        run_cmd(1, 1, 32'h0000_0040, 32'h5555_AAAA, 4'b1111, 1, 0, 0);       // R10 write wins

        // Random mix
        for (int k = 0; k < 60; k++) begin
            bit w, r;
            w = 1'($urandom % 2);
            r = w ? 1'($urandom % 4 == 0) : 1'b1;
            run_cmd(w, r, $urandom, $urandom, 4'($urandom), 1'($urandom % 2),
                    1'($urandom % 3 == 0), $urandom);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule